// File: doc/BRIEF.md
# Bit-Test Conditional Branch Sequencer

This block carries out the direct-page bit-test branch instructions of an 8-bit microcontroller core. Decode happens outside the block. The core pulses `start` together with the address of the already-fetched opcode and a decoded mode bit. The mode bit selects one of two conditions:

- branch when any selected bit is set;
- branch when all selected bits are clear.

Over a byte-wide read port with same-cycle data, the block then reads three inline bytes that follow the opcode: a page-zero address, a bit mask and a signed displacement. It reads the byte at that page-zero address, applies the mask, and decides whether the branch is taken.

The instruction always occupies six cycles. The first is the cycle in which `start` is accepted, and the last is the cycle in which `done` is high. The length is the same whether or not the branch is taken. While `done` is high, `next_pc` holds the address the core continues from, and `taken` tells whether that address is the branch target.

Top module: `bt_branch_seq`

## Requirements
- R1: A low `rst_n` at a rising clock edge (synchronous reset) brings `busy`, `done`, `bus_rd` and `taken` to 0.
- R2: After `start` is accepted at edge E0, the block asserts `bus_rd` in exactly the four following cycles, with these addresses:
  - cycle 1: `op_pc`+1, which returns the page address byte;
  - cycle 2: `op_pc`+2, which returns the mask byte;
  - cycle 3: `op_pc`+3, which returns the displacement byte;
  - cycle 4: the page address byte zero-extended to 16 bits, in the range 0x0000 to 0x00FF, which returns the tested byte.

  Operand addresses wrap modulo 2^16. `bus_rdata` must be valid in the same cycle as the address.
- R3: `done` is a single-cycle pulse that is high in the fifth cycle after E0, so one instruction spans six cycles. This timing is the same whether or not the branch is taken.
- R4: With `branch_if_set`=1, the branch is taken exactly when the tested byte AND the mask is non-zero. A mask of 0x00 therefore never branches.
- R5: With `branch_if_set`=0, the branch is taken exactly when the tested byte AND the mask is zero. A mask of 0x00 therefore always branches.
- R6: When the branch is taken, `next_pc` = `op_pc` + 4 + the sign-extended displacement, modulo 2^16.
- R7: When the branch is not taken, `next_pc` = `op_pc` + 4, modulo 2^16.
- R8: `start` is accepted only while `busy` is 0. A `start` pulse during an instruction has no effect. `op_pc` and `branch_if_set` are sampled only at an accepted start, so later changes to them do not alter the result.
- R9: `busy` is high from the cycle after the accepted start through the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| branch_if_set | input | 1 | 1: branch on any masked bit set; 0: branch on all masked bits clear |
| op_pc | input | 16 | Address of the opcode byte |
| bus_addr | output | 16 | Read address |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision, valid while `done` is high |
| next_pc | output | 16 | Continuation address, valid while `done` is high |

## Verification
A step counter that skips or repeats a state shows up at once on the read port. It appears in the same cycle as a missing, doubled or out-of-order address, and by the end of the instruction as a `done` pulse that comes too early or too late. A byte captured into the wrong operand register does not reach the ports until the `done` cycle. There it appears as a wrong `next_pc`, a wrong `taken`, or a tested address that points at the wrong page-zero location one cycle earlier. Masks of 0x00 and 0xFF, displacements of both signs, and operand and target addresses that wrap past 0xFFFF expose errors in the condition polarity, in sign extension and in the adder width.

// File: rtl/bt_pkg.sv
// Package: shared types for the bit-test branch sequencer.
// Assumes one instruction step per clock.
package bt_pkg;

    // Instruction steps after the start cycle, in bus order.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADR  = 3'd1,
        ST_MSK  = 3'd2,
        ST_REL  = 3'd3,
        ST_OPR  = 3'd4,
        ST_DONE = 3'd5
    } step_e;

endpackage

// File: rtl/bt_step_ctrl.sv
// Module: bt_step_ctrl
// Steps once through the fixed six-cycle sequence per accepted start.
// Assumes start is ignored unless idle; synchronous active-low reset.
module bt_step_ctrl
    import bt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output step_e step,
    output logic  busy,
    output logic  accept
);

    // Accept a new instruction only from idle.
    always_comb begin
        busy   = (step != ST_IDLE);
        accept = start && (step == ST_IDLE);
    end

    // Advance the step counter one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_IDLE;
        end else begin
            unique case (step)
                ST_IDLE: step <= accept ? ST_ADR : ST_IDLE;
                ST_ADR:  step <= ST_MSK;
                ST_MSK:  step <= ST_REL;
                ST_REL:  step <= ST_OPR;
                ST_OPR:  step <= ST_DONE;
                default: step <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bt_bus_addr.sv
// Module: bt_bus_addr
// Picks the read address for the current step.
// Assumes ADDR_W > DATA_W; the page address is zero-extended.
module bt_bus_addr
    import bt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  step_e              step,
    input  logic [ADDR_W-1:0]  pc_q,
    input  logic [DATA_W-1:0]  dir_q,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_rd
);

    localparam int PAD_W = ADDR_W - DATA_W;

    // Address mux: three inline operands, then the page-zero byte.
    always_comb begin
        bus_rd   = 1'b1;
        bus_addr = '0;
        unique case (step)
            ST_ADR:  bus_addr = pc_q + ADDR_W'(1);
            ST_MSK:  bus_addr = pc_q + ADDR_W'(2);
            ST_REL:  bus_addr = pc_q + ADDR_W'(3);
            ST_OPR:  bus_addr = {{PAD_W{1'b0}}, dir_q};
            default: bus_rd   = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_bit_test.sv
// Module: bt_bit_test
// Masked bit test; any-set or all-clear according to the mode bit.
// Assumes purely combinational use in the operand-read cycle.
module bt_bit_test #(
    parameter int DATA_W = 8
) (
    input  logic              on_set,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] value,
    output logic              hit
);

    // Branch decision from the masked value.
    always_comb begin
        if (on_set) hit = |(value & mask);
        else        hit = ~|(value & mask);
    end

endmodule

// File: rtl/bt_target.sv
// Module: bt_target
// Computes the fall-through and branch-target addresses, modulo 2^ADDR_W.
// Assumes the displacement is two's complement of width DATA_W.
module bt_target #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int INSTR_LEN = 4
) (
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [DATA_W-1:0] rel_q,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] dest_pc
);

    localparam int EXT_W = ADDR_W - DATA_W;

    // Sign-extend the displacement and add it to the fall-through address.
    always_comb begin
        fall_pc = pc_q + ADDR_W'(INSTR_LEN);
        dest_pc = fall_pc + {{EXT_W{rel_q[DATA_W-1]}}, rel_q};
    end

endmodule

// File: rtl/bt_branch_seq.sv
// Module: bt_branch_seq (top)
// Runs one direct-page bit-test branch: fetches address, mask and displacement
// bytes, reads the page-zero byte, and reports the continuation address.
// Assumes a read port whose data is valid in the cycle the address is driven.
module bt_branch_seq
    import bt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int INSTR_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              branch_if_set,
    input  logic [ADDR_W-1:0] op_pc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    step_e             step;
    logic              accept;
    logic              hit;
    logic              mode_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rel_q;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] dest_pc;

    bt_step_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .step   (step),
        .busy   (busy),
        .accept (accept)
    );

    bt_bus_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .step     (step),
        .pc_q     (pc_q),
        .dir_q    (dir_q),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd)
    );

    bt_bit_test #(.DATA_W(DATA_W)) u_test (
        .on_set (mode_q),
        .mask   (mask_q),
        .value  (bus_rdata),
        .hit    (hit)
    );

    bt_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSTR_LEN(INSTR_LEN)) u_tgt (
        .pc_q    (pc_q),
        .rel_q   (rel_q),
        .fall_pc (fall_pc),
        .dest_pc (dest_pc)
    );

    // Capture start context and the inline operand bytes in bus order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            pc_q   <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            rel_q  <= '0;
        end else begin
            if (accept) begin
                mode_q <= branch_if_set;
                pc_q   <= op_pc;
            end
            if (step == ST_ADR) dir_q  <= bus_rdata;
            if (step == ST_MSK) mask_q <= bus_rdata;
            if (step == ST_REL) rel_q  <= bus_rdata;
        end
    end

    // Register the decision and continuation address in the operand-read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            taken   <= 1'b0;
            next_pc <= '0;
        end else begin
            done <= (step == ST_OPR);
            if (step == ST_OPR) begin
                taken   <= hit;
                next_pc <= hit ? dest_pc : fall_pc;
            end
        end
    end

endmodule

// File: rtl/bt_branch_seq_chk.sv
// Module: bt_branch_seq_chk
// Protocol and timing checks for bt_branch_seq, attached by bind.
// Keeps its own start-to-done counter and captured opcode address.
module bt_branch_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              taken,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] op_pc,
    input logic [ADDR_W-1:0] next_pc
);

    logic              run;
    logic [3:0]        lat;
    logic [ADDR_W-1:0] pc_cap;

    // Independent cycle count since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            lat    <= '0;
            pc_cap <= '0;
        end else if (start && !busy) begin
            run    <= 1'b1;
            lat    <= 4'd1;
            pc_cap <= op_pc;
        end else if (run) begin
            lat <= lat + 4'd1;
            if (done) run <= 1'b0;
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !bus_rd && !taken));

    // R2
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> busy);

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lat == 4'd1) |-> (bus_rd && bus_addr == pc_cap + ADDR_W'(1)));

    // R3
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run && lat == 4'd5));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R7
    fall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (next_pc == pc_cap + ADDR_W'(4)));

endmodule

bind bt_branch_seq bt_branch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .taken    (taken),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .op_pc    (op_pc),
    .next_pc  (next_pc)
);

// File: tb/test_bt_branch_seq.sv
`timescale 1ns/1ps
// Bench for bt_branch_seq: vector table walk, then directed reset and corner tests.
module test_bt_branch_seq;

    typedef struct packed {
        logic        mode;
        logic [15:0] pc;
        logic [7:0]  dir;
        logic [7:0]  mask;
        logic [7:0]  rel;
        logic [7:0]  data;
        logic        exp_tk;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h1000, 8'h40, 8'h08, 8'h10, 8'h0F, 1'b1},
        '{1'b1, 16'h2000, 8'h41, 8'h80, 8'hF0, 8'h7F, 1'b0},
        '{1'b0, 16'h3000, 8'h42, 8'h81, 8'hF0, 8'h7E, 1'b1},
        '{1'b0, 16'h3100, 8'h43, 8'h81, 8'h20, 8'h01, 1'b0},
        '{1'b1, 16'h4000, 8'h44, 8'h00, 8'h10, 8'hFF, 1'b0},
        '{1'b0, 16'h4100, 8'h45, 8'h00, 8'h10, 8'hFF, 1'b1},
        '{1'b1, 16'h5000, 8'h46, 8'hFF, 8'h80, 8'h01, 1'b1},
        '{1'b0, 16'h5100, 8'h47, 8'hFF, 8'h7F, 8'h00, 1'b1},
        '{1'b0, 16'h5200, 8'h48, 8'hFF, 8'h7F, 8'h80, 1'b0},
        '{1'b1, 16'hFFFE, 8'h49, 8'h01, 8'h05, 8'h01, 1'b1},
        '{1'b1, 16'h0002, 8'h80, 8'h02, 8'hF0, 8'h02, 1'b1},
        '{1'b0, 16'h6000, 8'h4A, 8'h10, 8'hFC, 8'hEF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        branch_if_set = 1'b0;
    logic [15:0] op_pc = '0;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        busy, done, taken;
    logic [15:0] next_pc;

    int   n_chk = 0;
    int   n_bad = 0;
    vec_t cur = '0;

    always #4 clk = ~clk;

    bt_branch_seq i_bt_branch_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .branch_if_set (branch_if_set),
        .op_pc         (op_pc),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata),
        .busy          (busy),
        .done          (done),
        .taken         (taken),
        .next_pc       (next_pc)
    );

    // Sparse memory: inline operands of cur, then its page-zero byte.
    always_comb begin
        if (bus_addr == cur.pc + 16'd1)            bus_rdata = cur.dir;
        else if (bus_addr == cur.pc + 16'd2)       bus_rdata = cur.mask;
        else if (bus_addr == cur.pc + 16'd3)       bus_rdata = cur.rel;
        else if (bus_addr == {8'h00, cur.dir})     bus_rdata = cur.data;
        else                                       bus_rdata = 8'hEE;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic ref_tk(vec_t v);
        return v.mode ? ((v.data & v.mask) != 8'h00) : ((v.data & v.mask) == 8'h00);
    endfunction

    function automatic logic [15:0] ref_pc(vec_t v);
        return ref_tk(v) ? (v.pc + 16'd4 + {{8{v.rel[7]}}, v.rel}) : (v.pc + 16'd4);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Run one instruction; optionally disturb start/op_pc/mode mid-way (R8).
    task automatic run_vec(input vec_t v, input bit disturb);
        logic [15:0] alog [4];
        int nrd = 0;
        int lat = 0;
        cur = v;
        @(negedge clk);
        start = 1'b1; branch_if_set = v.mode; op_pc = v.pc;
        @(posedge clk);
        #1 start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                start = 1'b1; op_pc = 16'h7777; branch_if_set = ~v.mode;
            end
            if (disturb && lat == 4) start = 1'b0;
            if (bus_rd) begin
                if (nrd < 4) alog[nrd] = bus_addr;
                nrd++;
            end
            // R9: busy from the cycle after start through done
            chk(busy == 1'b1, "R9 busy", {31'd0, busy}, 32'd1);
            if (done) break;
        end
        // R3: six-cycle instruction, done five edges after the start edge
        chk(lat == 5, "R3 latency", lat, 5);
        // R2: four reads in the required order
        chk(nrd == 4, "R2 read count", nrd, 4);
        chk(alog[0] == v.pc + 16'd1, "R2 addr1", {16'd0, alog[0]}, {16'd0, v.pc + 16'd1});
        chk(alog[1] == v.pc + 16'd2, "R2 addr2", {16'd0, alog[1]}, {16'd0, v.pc + 16'd2});
        chk(alog[2] == v.pc + 16'd3, "R2 addr3", {16'd0, alog[2]}, {16'd0, v.pc + 16'd3});
        chk(alog[3] == {8'h00, v.dir}, "R2 page addr", {16'd0, alog[3]}, {24'd0, v.dir});
        // R4 / R5: decision (table value cross-checked against the rule)
        chk(ref_tk(v) == v.exp_tk, "R4 R5 table", {31'd0, v.exp_tk}, {31'd0, ref_tk(v)});
        chk(taken == v.exp_tk, v.mode ? "R4 taken" : "R5 taken", {31'd0, taken}, {31'd0, v.exp_tk});
        // R6 / R7: continuation address
        chk(next_pc == ref_pc(v), ref_tk(v) ? "R6 target" : "R7 fallthrough",
            {16'd0, next_pc}, {16'd0, ref_pc(v)});
        @(negedge clk);
        // R3: single-cycle pulse; R9: idle again
        chk(!done && !busy, "R3 pulse end", {30'd0, done, busy}, 32'd0);
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_rd && !taken, "R1 reset", {28'd0, busy, done, bus_rd, taken}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R8: start, op_pc and mode changed mid-instruction are ignored
        run_vec(VECS[0], 1'b1);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done || busy) extra = 1'b1;
            end
            chk(!extra, "R8 no restart", {31'd0, extra}, 32'd0);
        end

        // R1: reset in the middle of an instruction
        cur = VECS[2];
        @(negedge clk);
        start = 1'b1; branch_if_set = VECS[2].mode; op_pc = VECS[2].pc;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bus_rd, "R1 mid reset", {29'd0, busy, done, bus_rd}, 32'd0);
        rst_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done || bus_rd) seen = 1'b1;
            end
            chk(!seen, "R1 abort", {31'd0, seen}, 32'd0);
        end

        // Back-to-back after reset still works (R6)
        run_vec(VECS[10], 1'b0);

        summary();
        $finish;
    end

endmodule